// File: doc/BRIEF.md
# Early-Exit Iterative Integer Divider

This block divides two 32-bit integers, either as unsigned numbers or as two's-complement numbers, and returns a quotient and a remainder. It uses a restoring loop that settles one quotient bit per clock. Before the loop starts, it looks at the dividend magnitude. If the upper bytes are zero, it shortens the loop, so small dividends finish in fewer cycles than the 32-bit worst case.

A requester pulses `start` with the operands and the mode. It then waits for the one-cycle `done` pulse, and the results stay on the outputs until the next completion. A request that arrives while the unit is working is refused, and `stall` reports the refusal. The `abort` input abandons the current operation at the next edge. The requester must then issue the whole request again.

Top module: `div_early_exit`

## Requirements
- R1: In unsigned mode (`is_signed`=0), for a nonzero divisor, `quotient` = floor(dividend/divisor) and `remainder` = dividend mod divisor.
- R2: In signed mode (`is_signed`=1), the quotient truncates toward zero and the remainder takes the dividend's sign, so that dividend = quotient*divisor + remainder.
- R3: Let the start be accepted at edge E. Count how many of the three most significant bytes of the dividend magnitude are zero, counting downward from the top byte. For 0, 1, 2 or 3 such bytes the loop runs N = 32, 25, 17 or 9 cycles, and `done` rises N+2 edges after E (at most 34 edges, or 35 clocks counting the start cycle).
- R4: `done` is high for exactly one cycle per completed operation. `quotient` and `remainder` change only at the edge that raises `done`.
- R5: While `busy` is high, `stall` equals `start`, and such a request is not accepted, so it produces no result.
- R6: `abort` while busy returns the unit to idle at the next edge. That operation then produces no `done` pulse and leaves `quotient`/`remainder` unchanged, and a later reissue completes normally.
- R7: A zero divisor raises `done` 2 edges after acceptance, with `quotient` all ones and `remainder` equal to the raw dividend, in either mode.
- R8: In signed mode, 0x80000000 divided by 0xFFFFFFFF (-1) gives quotient 0x80000000 and remainder 0.
- R9: After reset, `busy`, `stall` and `done` are 0 and `quotient` and `remainder` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request a division; accepted when not busy |
| is_signed | input | 1 | 1 selects two's-complement operands |
| dividend | input | 32 | Dividend, sampled at acceptance |
| divisor | input | 32 | Divisor, sampled at acceptance |
| abort | input | 1 | Abandon the operation in progress |
| busy | output | 1 | An operation is in progress |
| stall | output | 1 | A request was refused because the unit is busy |
| done | output | 1 | One-cycle completion pulse |
| quotient | output | 32 | Quotient of the last completed operation |
| remainder | output | 32 | Remainder of the last completed operation |

## Verification
The embedded properties check these on every cycle:
- `done` is a single-cycle pulse.
- The results hold steady outside that pulse.
- `busy` rises only from an accepted idle request.
- An abort empties the unit at the next edge.
- A zero divisor bypasses the loop.
- The partial remainder stays below the divisor.

The numeric results, the 9/17/25/32-iteration latencies chosen by the prescan, the signed corner cases, and the behaviour of refused or abandoned requests are shown only by the scoreboard scenarios. These scenarios compare each result and its arrival cycle with values computed in the bench.

// File: rtl/div_pkg.sv
package div_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_SETUP = 2'd1,
        ST_ITER  = 2'd2,
        ST_FIX   = 2'd3
    } div_state_e;

    typedef struct packed {
        logic neg_q;   // quotient must be negated
        logic neg_r;   // remainder must be negated
        logic dz;      // divisor was zero
    } div_flags_t;

endpackage

// File: rtl/div_prescan.sv
module div_prescan #(
    parameter int W      = 32,
    parameter int BYTE_W = 8,
    parameter int CNT_W  = $clog2(W + 1)
) (
    input  logic [W-1:0]     mag,
    output logic [CNT_W-1:0] skip
);
    localparam int NB   = W / BYTE_W;
    localparam int MAXK = NB - 1;

    logic [MAXK:1] top_zero;

    generate
        for (genvar k = 1; k <= MAXK; k++) begin : g_zb
            assign top_zero[k] = ~|mag[W-1 -: k*BYTE_W];
        end
    endgenerate

    // largest run of leading zero bytes wins; one bit kept as a guard zero
    always_comb begin
        skip = '0;
        for (int k = 1; k <= MAXK; k++) begin
            if (top_zero[k]) skip = CNT_W'(k * BYTE_W - 1);
        end
    end
endmodule

// File: rtl/div_step.sv
module div_step #(
    parameter int W = 32
) (
    input  logic [W-1:0] rem_in,
    input  logic [W-1:0] q_in,
    input  logic [W-1:0] dvsr,
    output logic [W-1:0] rem_out,
    output logic [W-1:0] q_out
);
    logic [W:0] shifted;
    logic [W:0] diff;

    always_comb begin
        shifted = {rem_in, q_in[W-1]};
        diff    = shifted - {1'b0, dvsr};
        if (!diff[W]) begin
            rem_out = diff[W-1:0];
            q_out   = {q_in[W-2:0], 1'b1};
        end else begin
            rem_out = shifted[W-1:0];
            q_out   = {q_in[W-2:0], 1'b0};
        end
    end
endmodule

// File: rtl/div_sign_fix.sv
module div_sign_fix
    import div_pkg::*;
#(
    parameter int W = 32
) (
    input  logic [W-1:0] q_mag,
    input  logic [W-1:0] r_mag,
    input  logic [W-1:0] dvd_raw,
    input  div_flags_t   flags,
    output logic [W-1:0] q_out,
    output logic [W-1:0] r_out
);
    always_comb begin
        if (flags.dz) begin
            q_out = '1;
            r_out = dvd_raw;
        end else begin
            q_out = flags.neg_q ? (~q_mag + W'(1)) : q_mag;
            r_out = flags.neg_r ? (~r_mag + W'(1)) : r_mag;
        end
    end
endmodule

// File: rtl/div_early_exit.sv
module div_early_exit
    import div_pkg::*;
#(
    parameter int W      = 32,
    parameter int BYTE_W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         start,
    input  logic         is_signed,
    input  logic [W-1:0] dividend,
    input  logic [W-1:0] divisor,
    input  logic         abort,
    output logic         busy,
    output logic         stall,
    output logic         done,
    output logic [W-1:0] quotient,
    output logic [W-1:0] remainder
);
    localparam int CNT_W = $clog2(W + 1);

    div_state_e       st;
    div_flags_t       flags;
    logic [W-1:0]     dvd_raw;
    logic [W-1:0]     dvsr_r;
    logic [W-1:0]     rem_r;
    logic [W-1:0]     q_r;
    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] skip;
    logic [W-1:0]     rem_nx, q_nx;
    logic [W-1:0]     q_fin, r_fin;
    logic             a_neg, b_neg;
    logic [W-1:0]     mag_a, mag_b;

    assign busy  = (st != ST_IDLE);
    assign stall = start && busy;

    always_comb begin
        a_neg = is_signed && dividend[W-1];
        b_neg = is_signed && divisor[W-1];
        mag_a = a_neg ? (~dividend + W'(1)) : dividend;
        mag_b = b_neg ? (~divisor + W'(1)) : divisor;
    end

    div_prescan #(.W(W), .BYTE_W(BYTE_W), .CNT_W(CNT_W)) prescan_i (
        .mag  (q_r),
        .skip (skip)
    );

    div_step #(.W(W)) step_i (
        .rem_in  (rem_r),
        .q_in    (q_r),
        .dvsr    (dvsr_r),
        .rem_out (rem_nx),
        .q_out   (q_nx)
    );

    div_sign_fix #(.W(W)) fix_i (
        .q_mag   (q_r),
        .r_mag   (rem_r),
        .dvd_raw (dvd_raw),
        .flags   (flags),
        .q_out   (q_fin),
        .r_out   (r_fin)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            st        <= ST_IDLE;
            flags     <= '0;
            dvd_raw   <= '0;
            dvsr_r    <= '0;
            rem_r     <= '0;
            q_r       <= '0;
            cnt       <= '0;
            quotient  <= '0;
            remainder <= '0;
            done      <= 1'b0;
        end else begin
            done <= 1'b0;
            if (busy && abort) begin
                st <= ST_IDLE;
            end else begin
                unique case (st)
                    ST_IDLE: begin
                        if (start) begin
                            dvd_raw     <= dividend;
                            flags.neg_q <= a_neg ^ b_neg;
                            flags.neg_r <= a_neg;
                            flags.dz    <= (divisor == '0);
                            q_r         <= mag_a;
                            dvsr_r      <= mag_b;
                            rem_r       <= '0;
                            st          <= ST_SETUP;
                        end
                    end
                    ST_SETUP: begin
                        if (flags.dz) begin
                            st <= ST_FIX;
                        end else begin
                            q_r <= q_r << skip;
                            cnt <= CNT_W'(W) - skip;
                            st  <= ST_ITER;
                        end
                    end
                    ST_ITER: begin
                        q_r   <= q_nx;
                        rem_r <= rem_nx;
                        cnt   <= cnt - CNT_W'(1);
                        if (cnt == CNT_W'(1)) st <= ST_FIX;
                    end
                    ST_FIX: begin
                        quotient  <= q_fin;
                        remainder <= r_fin;
                        done      <= 1'b1;
                        st        <= ST_IDLE;
                    end
                    default: st <= ST_IDLE;
                endcase
            end
        end
    end

    a_r4_done_pulse: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    a_r4_hold_results: assert property (@(posedge clk) disable iff (rst)
        !done |-> ($stable(quotient) && $stable(remainder)));

    a_r5_accept_only_idle: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> ($past(start) && !$past(busy)));

    a_r6_abort_clears: assert property (@(posedge clk) disable iff (rst)
        (busy && abort) |=> (!busy && !done));

    a_r7_zero_bypass: assert property (@(posedge clk) disable iff (rst)
        (st == ST_SETUP && flags.dz && !abort) |=> (st == ST_FIX));

    a_r3_count_live: assert property (@(posedge clk) disable iff (rst)
        (st == ST_ITER) |-> (cnt != '0 && cnt <= CNT_W'(W)));

    a_r1_rem_bound: assert property (@(posedge clk) disable iff (rst)
        (st == ST_ITER) |-> (rem_r < dvsr_r));

endmodule

// File: tb/div_early_exit_tb_top.sv
`timescale 1ns/1ps
module div_early_exit_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic        is_signed = 1'b0;
    logic [31:0] dividend = '0;
    logic [31:0] divisor = '0;
    logic        abort = 1'b0;
    logic        busy, stall, done;
    logic [31:0] quotient, remainder;

    always #2 clk = ~clk;

    div_early_exit dut_i (
        .clk(clk), .rst(rst), .start(start), .is_signed(is_signed),
        .dividend(dividend), .divisor(divisor), .abort(abort),
        .busy(busy), .stall(stall), .done(done),
        .quotient(quotient), .remainder(remainder)
    );

    typedef struct {
        logic [31:0] q;
        logic [31:0] r;
        int          due;
        string       tag;
    } exp_t;

    exp_t        sb[$];
    int          total = 0;
    int          bad = 0;
    int          ncyc = 0;
    logic        prev_done = 1'b0;
    logic [31:0] last_q = '0;
    logic [31:0] last_r = '0;

    task automatic chk(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] expv);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, expv);
        end
    endtask

    function automatic int iters(input logic [31:0] a, input logic sgn);
        logic [31:0] m;
        int kk;
        m = (sgn && a[31]) ? (~a + 32'd1) : a;
        kk = 0;
        for (int k = 1; k <= 3; k++)
            if ((m >> (32 - 8*k)) == 0) kk = k;
        return (kk == 0) ? 32 : 32 - (8*kk - 1);
    endfunction

    // monitor: pops scoreboard on each done pulse
    always @(negedge clk) begin
        ncyc++;
        if (!rst && done) begin
            chk(!prev_done, "R4 done single pulse", {31'd0, prev_done}, 32'd0);
            if (sb.size() == 0) begin
                chk(1'b0, "R6/R5 unexpected done", 32'd1, 32'd0);
            end else begin
                exp_t e;
                e = sb.pop_front();
                chk(quotient == e.q, {e.tag, " quotient"}, quotient, e.q);
                chk(remainder == e.r, {e.tag, " remainder"}, remainder, e.r);
                chk(ncyc == e.due, {"R3 latency ", e.tag}, ncyc, e.due);
            end
            last_q = quotient;
            last_r = remainder;
        end
        prev_done = done;
    end

    task automatic drive_start(input logic [31:0] a, input logic [31:0] b, input logic sgn, output int acc);
        @(negedge clk);
        while (busy) @(negedge clk);
        #1;
        start = 1'b1; is_signed = sgn; dividend = a; divisor = b;
        acc = ncyc;
        @(negedge clk);
        #1;
        start = 1'b0;
    endtask

    task automatic issue(input logic [31:0] a, input logic [31:0] b, input logic sgn, input string tag);
        exp_t e;
        int acc;
        int sa, sb_;
        if (b == 0) begin
            e.q = 32'hFFFF_FFFF; e.r = a;
        end else if (sgn && a == 32'h8000_0000 && b == 32'hFFFF_FFFF) begin
            e.q = 32'h8000_0000; e.r = 32'd0;
        end else if (sgn) begin
            sa = a; sb_ = b;
            e.q = sa / sb_; e.r = sa % sb_;
        end else begin
            e.q = a / b; e.r = a % b;
        end
        e.tag = tag;
        drive_start(a, b, sgn, acc);
        e.due = (b == 0) ? acc + 3 : acc + iters(a, sgn) + 3;
        sb.push_back(e);
    endtask

    task automatic wait_idle();
        @(negedge clk);
        while (busy || sb.size() != 0) @(negedge clk);
        @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R9 reset state
        chk(busy == 0, "R9 busy after reset", busy, 0);
        chk(done == 0, "R9 done after reset", done, 0);
        chk(stall == 0, "R9 stall after reset", stall, 0);
        chk(quotient == 0, "R9 quotient after reset", quotient, 0);
        chk(remainder == 0, "R9 remainder after reset", remainder, 0);
        rst = 1'b0;

        // R1 unsigned, all four loop lengths (R3)
        issue(32'd100, 32'd7, 0, "R1 100/7");
        issue(32'hFFFF_FFFF, 32'd3, 0, "R1 max/3");
        issue(32'h0001_2345, 32'h10, 0, "R1 one zero byte");
        issue(32'h0000_1234, 32'h35, 0, "R1 two zero bytes");
        issue(32'h0000_00AB, 32'd5, 0, "R1 three zero bytes");
        issue(32'd3, 32'd10, 0, "R1 divisor larger");
        issue(32'hFFFF_FFFF, 32'd1, 0, "R1 max/1");
        wait_idle();

        // R2 signed
        issue(-32'sd100, 32'd7, 1, "R2 -100/7");
        issue(32'd100, -32'sd7, 1, "R2 100/-7");
        issue(-32'sd100, -32'sd7, 1, "R2 -100/-7");
        issue(32'h7FFF_FFFF, -32'sd2, 1, "R2 maxpos/-2");
        issue(-32'sd1, 32'd1, 1, "R2 -1/1");
        // R8 wraparound corner
        issue(32'h8000_0000, 32'hFFFF_FFFF, 1, "R8 minneg/-1");
        // R7 zero divisor
        issue(32'd55, 32'd0, 0, "R7 unsigned by zero");
        issue(-32'sd5, 32'd0, 1, "R7 signed by zero");
        wait_idle();

        // R5 stall while busy
        issue(32'h1234_5678, 32'd9, 0, "R5 running op");
        @(negedge clk); #1;
        start = 1'b1; dividend = 32'd1; divisor = 32'd1; is_signed = 1'b0;
        #1;
        chk(stall == 1'b1, "R5 stall while busy", stall, 1);
        repeat (3) @(negedge clk);
        #1;
        chk(stall == 1'b1, "R5 stall held", stall, 1);
        start = 1'b0;
        #1;
        chk(stall == 1'b0, "R5 stall drops with start", stall, 0);
        wait_idle();
        repeat (5) @(negedge clk);

        // R6 abort: no result, outputs unchanged, reissue works
        begin
            int acc;
            logic [31:0] hq, hr;
            hq = last_q; hr = last_r;
            drive_start(32'hDEAD_BEEF, 32'd77, 0, acc);
            repeat (5) @(negedge clk);
            #1 abort = 1'b1;
            @(negedge clk);
            #1 abort = 1'b0;
            chk(busy == 1'b0, "R6 idle after abort", busy, 0);
            chk(quotient == hq, "R6 quotient kept", quotient, hq);
            chk(remainder == hr, "R6 remainder kept", remainder, hr);
            repeat (40) @(negedge clk);
            chk(quotient == hq, "R6 no late result", quotient, hq);
        end
        issue(32'hDEAD_BEEF, 32'd77, 0, "R6 reissue");
        wait_idle();

        // back-to-back issues
        issue(32'h0000_0FFF, 32'd16, 0, "R1 back-to-back a");
        issue(32'hFFFF_0000, 32'hFFFF, 1, "R2 back-to-back b");
        wait_idle();

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog expired actual=%0d expected=0", ncyc);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule